// File: doc/BRIEF.md
# Streaming Complex-Array Multiplier

This block takes two arrays of complex fixed-point numbers, multiplies them element by element, and writes the array of complex products back to memory. The operands and results sit in two single-port memory banks, and each bank is accessed at most once per clock. Bank A holds the real parts of both input arrays and the imaginary part of the result. Bank B holds the imaginary parts of both input arrays and the real part of the result.

Each element takes four real multiplies, one addition and one subtraction. A single multiplier and a single add/subtract unit handle all of them on a fixed four-cycle rotation. The operand fetches for the next element overlap the arithmetic of the current one. A two-cycle prologue brings in the first operands, and a short epilogue finishes the last subtraction and the last store.

A run is launched with a one-cycle start pulse, which carries the element count and six base addresses. The block signals the end of the run with a one-cycle done pulse.

Top module: `cxmul_stream`

## Requirements
- R1: The value written to bank B at `zr_base+n` is the low RW bits of the exact two's-complement value xr·yr − xi·yi.
- R2: The value written to bank A at `zi_base+n` is the low RW bits of the exact two's-complement value xr·yi + xi·yr.
- R3: Operands are taken from the low DW bits of each memory word, read as two's complement; the upper word bits have no effect. For element n, xr is read from bank A at `xr_base+n`, yr from bank A at `yr_base+n`, xi from bank B at `xi_base+n`, and yi from bank B at `yi_base+n`.
- R4: Each bank has one port, which performs at most one access per cycle. A read issued with `*_en`=1 and `*_we`=0 returns its data on `*_rdata` in the following cycle. `*_we` is only ever high together with `*_en`.
- R5: Elements advance one every four cycles, and consecutive result writes are exactly four cycles apart. `done` is first seen high exactly 4·N+4 rising edges after the edge that sampled `start`.
- R6: Both halves of each element's result are written in the same cycle. A run makes exactly N such paired writes.
- R7: `done` is a one-cycle pulse in the cycle after the last paired write.
- R8: A `start` pulse that arrives while a run is in progress is ignored: the count, the timing and the results of that run are unchanged.
- R9: No result write lands outside `[zr_base, zr_base+N)` in bank B or `[zi_base, zi_base+N)` in bank A.
- R10: During reset, and between runs, both memory enables are low and `done` is low.
- R11: Runs of any length N ≥ 2 are supported. A start with a count below 2 is a usage error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle launch pulse, sampled while idle |
| count | input | CW | Number of elements N |
| xr_base | input | AW | Bank A base of the first input's real parts |
| yr_base | input | AW | Bank A base of the second input's real parts |
| zi_base | input | AW | Bank A base of the result's imaginary parts |
| xi_base | input | AW | Bank B base of the first input's imaginary parts |
| yi_base | input | AW | Bank B base of the second input's imaginary parts |
| zr_base | input | AW | Bank B base of the result's real parts |
| a_en | output | 1 | Bank A access enable |
| a_we | output | 1 | Bank A write enable |
| a_addr | output | AW | Bank A address |
| a_wdata | output | RW | Bank A write data (imaginary result) |
| a_rdata | input | RW | Bank A read data, one cycle after the read |
| b_en | output | 1 | Bank B access enable |
| b_we | output | 1 | Bank B write enable |
| b_addr | output | AW | Bank B address |
| b_wdata | output | RW | Bank B write data (real result) |
| b_rdata | input | RW | Bank B read data, one cycle after the read |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The bound checker watches the port-level protocol on every cycle. It checks that the two stores are paired, that stores are four cycles apart, that write enables appear only with access enables, and that the memories are quiet while idle. It also checks that done is a single pulse following a store, that the number of stores matches the latched count, and that the count is legal. Only the bench's scenarios can show that the arithmetic is correct, including the wrap on overflow and the fact that upper operand bits are ignored. The same holds for the exact end-to-end latency, for guard words around the result regions staying untouched, and for a start pulse during a run leaving that run unchanged. The bench covers every pair of first-operand values against several second-operand patterns, plus extreme values.

// File: rtl/cxm_pkg.sv
package cxm_pkg;
   // Four-cycle rotation; the value equals the low two bits of the run cycle count.
   typedef enum logic [1:0] {
      PH_F0  = 2'd0,   // fetch xr/yi, multiply xr*yr, add -> imaginary result
      PH_F1  = 2'd1,   // fetch yr/xi, multiply xi*yi, latch xr/yi
      PH_SUB = 2'd2,   // multiply xr*yi, subtract -> real result, latch yr/xi
      PH_ST  = 2'd3    // multiply xi*yr, paired store of the previous element
   } phase_e;

   localparam int NBANK = 2;   // bank 0 = A, bank 1 = B
endpackage

// File: rtl/cxm_seq.sv
module cxm_seq
   import cxm_pkg::*;
#(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [CW-1:0] count,
   output logic          run,
   output phase_e        ph,
   output logic          rd_go,
   output logic          wr_go,
   output logic [CW-1:0] elem_rd,
   output logic [CW-1:0] elem_wr,
   output logic          done
);
   localparam int TW = CW + 3;   // holds 4*N+3
   localparam int BW = TW - 2;   // element block index

   generate
      if (CW < 2) begin : g_bad_cw
         $error("cxm_seq: CW must be at least 2");
      end
   endgenerate

   logic [TW-1:0] cyc;
   logic [CW-1:0] n_q;
   logic [TW-1:0] last_cyc;
   logic [BW-1:0] blk;
   logic [BW-1:0] blk_m1;
   logic [BW-1:0] n_ext;

   assign last_cyc = {1'b0, n_q, 2'b11};
   assign blk      = cyc[TW-1:2];
   assign blk_m1   = blk - BW'(1);
   assign n_ext    = {1'b0, n_q};
   assign ph       = phase_e'(cyc[1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run  <= 1'b0;
         cyc  <= '0;
         n_q  <= '0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!run) begin
            if (start) begin
               run <= 1'b1;
               cyc <= '0;
               n_q <= count;
            end
         end else begin
            cyc <= cyc + TW'(1);
            if (cyc == last_cyc) begin
               run  <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end

   assign rd_go   = run && (ph == PH_F0 || ph == PH_F1) && (blk < n_ext);
   assign wr_go   = run && (ph == PH_ST) && (blk != '0) && (blk <= n_ext);
   assign elem_rd = blk[CW-1:0];
   assign elem_wr = blk_m1[CW-1:0];
endmodule

// File: rtl/cxm_agen.sv
module cxm_agen
   import cxm_pkg::*;
#(
   parameter int AW = 16,
   parameter int CW = 16
) (
   input  phase_e                    ph,
   input  logic                      rd_go,
   input  logic                      wr_go,
   input  logic [CW-1:0]             elem_rd,
   input  logic [CW-1:0]             elem_wr,
   input  logic [NBANK-1:0][AW-1:0]  rd0_base,
   input  logic [NBANK-1:0][AW-1:0]  rd1_base,
   input  logic [NBANK-1:0][AW-1:0]  wr_base,
   output logic [NBANK-1:0]          en,
   output logic [NBANK-1:0]          we,
   output logic [NBANK-1:0][AW-1:0]  addr
);
   logic [AW-1:0] off_rd;
   logic [AW-1:0] off_wr;

   assign off_rd = AW'(elem_rd);
   assign off_wr = AW'(elem_wr);

   for (genvar g = 0; g < NBANK; g++) begin : g_bank
      assign en[g]   = rd_go | wr_go;
      assign we[g]   = wr_go;
      assign addr[g] = wr_go         ? wr_base[g]  + off_wr :
                       (ph == PH_F1) ? rd1_base[g] + off_rd :
                                       rd0_base[g] + off_rd;
   end
endmodule

// File: rtl/cxm_arith.sv
module cxm_arith
   import cxm_pkg::*;
#(
   parameter int DW = 16,
   parameter int RW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  phase_e        ph,
   input  logic [RW-1:0] a_rdata,
   input  logic [RW-1:0] b_rdata,
   output logic [RW-1:0] re_q,
   output logic [RW-1:0] im_q
);
   localparam int PW = 2 * DW;
   localparam int SW = PW + 1;

   generate
      if (DW < 2 || RW < DW || RW > SW) begin : g_bad_width
         $error("cxm_arith: need 2 <= DW <= RW <= 2*DW+1");
      end
   endgenerate

   logic signed [DW-1:0] xr, xi, yr, yi;
   logic signed [DW-1:0] ma, mb;
   logic signed [DW-1:0] a_op, b_op;
   logic signed [PW-1:0] mres, prod, hold;
   logic        [SW-1:0] asum;
   logic        [RW-1:0] trunc;

   assign a_op = a_rdata[DW-1:0];
   assign b_op = b_rdata[DW-1:0];

   // single shared multiplier, operands steered by phase
   always_comb begin
      case (ph)
         PH_F0:   begin ma = xr; mb = yr; end
         PH_F1:   begin ma = xi; mb = yi; end
         PH_SUB:  begin ma = xr; mb = yi; end
         default: begin ma = xi; mb = yr; end
      endcase
   end

   assign mres = $signed({{DW{ma[DW-1]}}, ma}) * $signed({{DW{mb[DW-1]}}, mb});

   // single shared add/subtract unit at full width, then truncated
   assign asum  = (ph == PH_F0) ? ({hold[PW-1], hold} + {prod[PW-1], prod})
                                : ({hold[PW-1], hold} - {prod[PW-1], prod});
   assign trunc = asum[RW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xr   <= '0;
         xi   <= '0;
         yr   <= '0;
         yi   <= '0;
         prod <= '0;
         hold <= '0;
         re_q <= '0;
         im_q <= '0;
      end else if (run) begin
         prod <= mres;
         case (ph)
            PH_F0: begin
               im_q <= trunc;
            end
            PH_F1: begin
               hold <= prod;
               xr   <= a_op;
               yi   <= b_op;
            end
            PH_SUB: begin
               re_q <= trunc;
               yr   <= a_op;
               xi   <= b_op;
            end
            default: begin
               hold <= prod;
            end
         endcase
      end
   end
endmodule

// File: rtl/cxmul_stream.sv
module cxmul_stream
   import cxm_pkg::*;
#(
   parameter int DW = 16,
   parameter int RW = 32,
   parameter int AW = 16,
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [CW-1:0] count,
   input  logic [AW-1:0] xr_base,
   input  logic [AW-1:0] yr_base,
   input  logic [AW-1:0] zi_base,
   input  logic [AW-1:0] xi_base,
   input  logic [AW-1:0] yi_base,
   input  logic [AW-1:0] zr_base,
   output logic          a_en,
   output logic          a_we,
   output logic [AW-1:0] a_addr,
   output logic [RW-1:0] a_wdata,
   input  logic [RW-1:0] a_rdata,
   output logic          b_en,
   output logic          b_we,
   output logic [AW-1:0] b_addr,
   output logic [RW-1:0] b_wdata,
   input  logic [RW-1:0] b_rdata,
   output logic          done
);
   logic                     run, rd_go, wr_go;
   phase_e                   ph;
   logic [CW-1:0]            elem_rd, elem_wr;
   logic [NBANK-1:0]         en, we;
   logic [NBANK-1:0][AW-1:0] addr;
   logic [RW-1:0]            re_q, im_q;

   cxm_seq #(.CW(CW)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .count   (count),
      .run     (run),
      .ph      (ph),
      .rd_go   (rd_go),
      .wr_go   (wr_go),
      .elem_rd (elem_rd),
      .elem_wr (elem_wr),
      .done    (done)
   );

   cxm_agen #(.AW(AW), .CW(CW)) u_agen (
      .ph       (ph),
      .rd_go    (rd_go),
      .wr_go    (wr_go),
      .elem_rd  (elem_rd),
      .elem_wr  (elem_wr),
      .rd0_base ({yi_base, xr_base}),
      .rd1_base ({xi_base, yr_base}),
      .wr_base  ({zr_base, zi_base}),
      .en       (en),
      .we       (we),
      .addr     (addr)
   );

   cxm_arith #(.DW(DW), .RW(RW)) u_arith (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .ph      (ph),
      .a_rdata (a_rdata),
      .b_rdata (b_rdata),
      .re_q    (re_q),
      .im_q    (im_q)
   );

   assign a_en    = en[0];
   assign a_we    = we[0];
   assign a_addr  = addr[0];
   assign a_wdata = im_q;
   assign b_en    = en[1];
   assign b_we    = we[1];
   assign b_addr  = addr[1];
   assign b_wdata = re_q;
endmodule

// File: rtl/cxm_chk.sv
module cxm_chk #(
   parameter int CW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic [CW-1:0] count,
   input logic          a_en,
   input logic          a_we,
   input logic          b_en,
   input logic          b_we,
   input logic          done
);
   logic          busy;
   logic [CW-1:0] n_lat;
   logic [CW-1:0] wcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         n_lat <= '0;
         wcnt  <= '0;
      end else if (!busy) begin
         if (start) begin
            busy  <= 1'b1;
            n_lat <= count;
            wcnt  <= '0;
         end
      end else if (done) begin
         busy <= 1'b0;
      end else if (a_en && a_we) begin
         wcnt <= wcnt + CW'(1);
      end
   end

   AST_PAIR_A_B: assert property (@(posedge clk) disable iff (!rst_n)
      (a_en && a_we) |-> (b_en && b_we));                                // R6
   AST_PAIR_B_A: assert property (@(posedge clk) disable iff (!rst_n)
      (b_en && b_we) |-> (a_en && a_we));                                // R6
   AST_WE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      (a_we |-> a_en) and (b_we |-> b_en));                              // R4
   AST_STORE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      a_we |-> (!$past(a_we) && !$past(a_we, 2) && !$past(a_we, 3)));   // R5
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                                   // R7
   AST_DONE_AFTER_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(a_we && b_we));                                     // R7
   AST_STORE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (wcnt == n_lat));                                         // R6
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!a_en && !b_en && !done));                              // R10
   AST_LEN_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |-> (count >= CW'(2)));                           // R11
endmodule

bind cxmul_stream cxm_chk #(.CW(CW)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .start (start),
   .count (count),
   .a_en  (a_en),
   .a_we  (a_we),
   .b_en  (b_en),
   .b_we  (b_we),
   .done  (done)
);

// File: tb/sim_cxmul_stream.sv
`timescale 1ns/1ps
module sim_cxmul_stream;
   localparam int DW = 4;
   localparam int RW = 8;
   localparam int AW = 10;
   localparam int CW = 9;
   localparam int DEPTH = 1 << AW;
   localparam int XR_B = 0,   YR_B = 256, ZI_B = 520;
   localparam int YI_B = 0,   XI_B = 256, ZR_B = 520;
   localparam logic [RW-1:0] GUARD = 8'h5A;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [CW-1:0] count = '0;
   logic          a_en, a_we, b_en, b_we, done;
   logic [AW-1:0] a_addr, b_addr;
   logic [RW-1:0] a_wdata, b_wdata;
   logic [RW-1:0] a_rdata = '0, b_rdata = '0;

   always #2 clk = ~clk;   // 250 MHz

   cxmul_stream #(.DW(DW), .RW(RW), .AW(AW), .CW(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .count(count),
      .xr_base(AW'(XR_B)), .yr_base(AW'(YR_B)), .zi_base(AW'(ZI_B)),
      .xi_base(AW'(XI_B)), .yi_base(AW'(YI_B)), .zr_base(AW'(ZR_B)),
      .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
      .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata),
      .done(done)
   );

   logic [RW-1:0] mem_a [DEPTH];
   logic [RW-1:0] mem_b [DEPTH];

   always @(posedge clk) begin
      if (a_en) begin
         if (a_we) mem_a[a_addr] <= a_wdata;
         else      a_rdata <= mem_a[a_addr];
      end
      if (b_en) begin
         if (b_we) mem_b[b_addr] <= b_wdata;
         else      b_rdata <= mem_b[b_addr];
      end
   end

   int n_cmp = 0, n_bad = 0;
   int cyc_tb = 0;
   bit job_active = 1'b0;
   int wa, wb, pair_bad, gap_bad, idle_acc, last_w;

   always @(posedge clk) cyc_tb++;

   always @(negedge clk) begin
      if (rst_n) begin
         if (a_en && a_we) wa++;
         if (b_en && b_we) wb++;
         if ((a_en && a_we) != (b_en && b_we)) pair_bad++;
         if (a_en && a_we) begin
            if (last_w >= 0 && cyc_tb - last_w != 4) gap_bad++;
            last_w = cyc_tb;
         end
         if (!job_active && (a_en || b_en)) idle_acc++;
      end
   end

   task automatic chk(input bit ok, input string req, input longint act,
                      input longint exp, input string what);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [3:0] nib(input int i, input int mode, input int which);
      int v;
      case (mode)
         4: v = 8;
         5: v = (which == 1) ? 7 : 8;
         default: begin
            case (which)
               0: v = i;
               1: v = i >> 4;
               2: v = i * (2 * mode + 3) + mode;
               default: v = i * (4 * mode + 5) + 7 + 3 * mode;
            endcase
         end
      endcase
      return v[3:0];
   endfunction

   function automatic int sx(input logic [3:0] v);
      return v[3] ? int'(v) - 16 : int'(v);
   endfunction

   task automatic run_job(input int n, input int mode, input bit mid);
      int cnt;
      int xr, xi, yr, yi, er, ei;
      logic [RW-1:0] er8, ei8;
      for (int i = 0; i < n; i++) begin
         mem_a[XR_B + i] = {4'hA, nib(i, mode, 0)};
         mem_b[XI_B + i] = {4'h5, nib(i, mode, 1)};
         mem_a[YR_B + i] = {4'hC, nib(i, mode, 2)};
         mem_b[YI_B + i] = {4'h3, nib(i, mode, 3)};
      end
      for (int i = -1; i <= n; i++) begin
         mem_a[ZI_B + i] = GUARD;
         mem_b[ZR_B + i] = GUARD;
      end
      wa = 0; wb = 0; pair_bad = 0; gap_bad = 0; idle_acc = 0; last_w = -1;
      @(negedge clk);
      count = CW'(n);
      start = 1'b1;
      job_active = 1'b1;
      @(posedge clk);
      #1 start = 1'b0;
      cnt = 0;
      do begin
         @(posedge clk);
         cnt++;
         #1;
         if (mid && cnt == 6) begin start = 1'b1; count = CW'(5); end
         else start = 1'b0;
      end while (!done && cnt < 5000);
      job_active = 1'b0;
      chk(cnt == 4 * n + 4, "R5", cnt, 4 * n + 4, "edges from start to done");
      if (mid) chk(cnt == 4 * n + 4, "R8", cnt, 4 * n + 4, "latency with start during run");
      @(posedge clk);
      #1 chk(done == 1'b0, "R7", done, 0, "done one cycle wide");
      repeat (3) @(posedge clk);
      #1;
      for (int i = 0; i < n; i++) begin
         xr = sx(nib(i, mode, 0)); xi = sx(nib(i, mode, 1));
         yr = sx(nib(i, mode, 2)); yi = sx(nib(i, mode, 3));
         er = xr * yr - xi * yi;
         ei = xr * yi + xi * yr;
         er8 = er[RW-1:0];
         ei8 = ei[RW-1:0];
         chk(mem_b[ZR_B + i] == er8, "R1", mem_b[ZR_B + i], er8, "real result");
         chk(mem_a[ZI_B + i] == ei8, "R2", mem_a[ZI_B + i], ei8, "imag result");
      end
      chk(mem_b[ZR_B - 1] == GUARD && mem_b[ZR_B + n] == GUARD, "R9",
          mem_b[ZR_B + n], GUARD, "bank B guard words");
      chk(mem_a[ZI_B - 1] == GUARD && mem_a[ZI_B + n] == GUARD, "R9",
          mem_a[ZI_B + n], GUARD, "bank A guard words");
      chk(wa == n && wb == n, "R6", wa, n, "paired write count");
      if (mid) chk(wa == n, "R8", wa, n, "write count with start during run");
      chk(pair_bad == 0, "R6", pair_bad, 0, "unpaired write cycles");
      chk(gap_bad == 0, "R5", gap_bad, 0, "write spacing violations");
      chk(idle_acc == 0, "R10", idle_acc, 0, "accesses while idle");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) begin
         mem_a[i] = '0;
         mem_b[i] = '0;
      end
      repeat (4) @(posedge clk);
      #1;
      chk(done == 1'b0, "R10", done, 0, "done in reset");
      chk(a_en == 1'b0 && b_en == 1'b0, "R10", a_en, 0, "enables in reset");
      rst_n = 1'b1;
      repeat (2) @(posedge clk);
      #1 chk(a_en == 1'b0 && b_en == 1'b0 && done == 1'b0, "R10", a_en, 0, "quiet after reset");
      run_job(256, 0, 1'b0);   // R3 upper operand bits carry junk throughout
      run_job(256, 1, 1'b0);
      run_job(256, 2, 1'b1);   // R8 start pulse during the run
      run_job(256, 3, 1'b0);
      run_job(2, 4, 1'b0);     // R11 shortest run, all operands most negative
      run_job(2, 5, 1'b0);     // R1 R2 mixed extremes
      run_job(3, 1, 1'b1);     // R8 R11 short run with ignored start
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule